// File: doc/BRIEF.md
# Bus-Programmed Gain Control Register

This block is the digital control section of a programmable logarithmic gain/attenuator. A microprocessor writes a gain word over a parallel bus using an active-low chip select, a write strobe and, in the narrow-bus variant, one address line. The block keeps a direction bit, a 4-bit coarse code (1.5 dB per step, 0 to 22.5 dB) and a 4-bit fine code (0.1 dB per step, 0 to 1.5 dB). The two stages add in dB, so the whole setting spans -24 dB to +24 dB in 0.1 dB steps. The narrow-bus variant also keeps a power-down bit.

The bus control lines are asynchronous to the system clock. They pass through a synchronizer, and a write is taken on a rising edge of the synchronized strobe. The stored codes are decoded into two registered one-hot vectors, each choosing one of the 16 taps on a resistor-string switch bank. The block also drives a direction output, an analog enable and an output-tristate control. Parameter `BUS_NINE` picks the variant: 0 gives an 8-bit bus that needs two addressed writes, and 1 gives a 9-bit bus that loads everything in one write.

Top module: `gainctl_top`

## Requirements
- R1: In 8-bit mode (`BUS_NINE`=0), an accepted write with `addr`=0 loads the direction from `bus_data[8]` (1 = attenuate, 0 = gain), the coarse code from `bus_data[7:4]` and fine bits 3..1 from `bus_data[3:1]`. `bus_data[0]`, fine bit 0 and power-down keep their values.
- R2: In 8-bit mode, an accepted write with `addr`=1 loads power-down from `bus_data[2]` and fine bit 0 from `bus_data[1]`. Direction, coarse and fine bits 3..1 keep their values.
- R3: In 9-bit mode (`BUS_NINE`=1), one accepted write loads direction, coarse and fine bits 3..1 as in R1, and fine bit 0 from `bus_data[0]`. `addr` has no effect, and power-down stays 0.
- R4: A write is accepted only on a rising edge of the synchronized `wr_strobe` while the synchronized `cs_n` is low. With `cs_n` high nothing changes. A strobe held high gives exactly one write.
- R5: With `SYNC_STAGES`=2, let edge k be the first clock edge that samples `wr_strobe` high. The data is sampled at edge k+2, `addr` and `cs_n` are sampled at edge k, and the outputs show the new setting after edge k+3.
- R6: `coarse_tap` and `fine_tap` each have exactly one bit set, at the index equal to the stored 4-bit code. Code 0 (0 dB tap) sets bit 0 and code 15 sets bit 15.
- R7: With power-down at 1, `analog_en` is 0 and `out_hiz` is 1. With power-down at 0, they are 1 and 0. While powered down, the stored gain is kept and writes are still accepted.
- R8: Synchronous reset sets both codes to 0, direction to gain, power-down to 0 and `upd_pulse` to 0. As a result `coarse_tap` = `fine_tap` = 16'h0001.
- R9: `upd_pulse` is high for exactly one cycle, in the cycle in which the outputs first show an accepted write, even when the value is unchanged. At all other times it is low, and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Asynchronous write strobe; a rising edge writes |
| cs_n | input | 1 | Asynchronous active-low chip select |
| addr | input | 1 | Register select in 8-bit mode; has no effect in 9-bit mode |
| bus_data | input | 9 | Parallel write data |
| coarse_tap | output | 16 | One-hot coarse tap select |
| fine_tap | output | 16 | One-hot fine tap select |
| atten_sel | output | 1 | 1 = attenuate, 0 = gain |
| analog_en | output | 1 | Analog section enable |
| out_hiz | output | 1 | Output tristate control |
| upd_pulse | output | 1 | One-cycle pulse when new settings take effect |

## Verification
The hardest case to reach from the ports is a setting that lands in halves while the device is powered down. The fine code's low bit and the power-down flag share the address-1 register, and the other fine bits come through address 0. The stimulus therefore interleaves address-1 writes that set power-down, address-0 writes made while powered down, and a write with chip select high. It also holds the strobe high for many cycles. A behavioural model of both bus variants checks every output on every clock, and a long run of pseudo-random words with random addresses follows.

// File: rtl/gainctl_pkg.sv
package gainctl_pkg;
    localparam int CODE_W = 4;
    localparam int TAPS   = 1 << CODE_W;
    localparam int BUS_W  = 2 * CODE_W + 1;

    typedef struct packed {
        logic              atten;
        logic [CODE_W-1:0] coarse;
        logic [CODE_W-1:0] fine;
    } gain_word_t;

    typedef struct packed {
        gain_word_t gain;
        logic       pdn;
    } ctl_state_t;

    function automatic logic [TAPS-1:0] tap_onehot(input logic [CODE_W-1:0] code);
        return TAPS'(1) << code;
    endfunction
endpackage

// File: rtl/gainctl_sync.sv
module gainctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_strobe,
    input  logic cs_n,
    input  logic addr,
    output logic wr_fire,
    output logic addr_s
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] wr_q, cs_q, ad_q;
    logic              wr_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= '0;
            cs_q    <= '1;
            ad_q    <= '0;
            wr_last <= 1'b0;
        end else begin
            wr_q    <= {wr_q[STAGES-2:0], wr_strobe};
            cs_q    <= {cs_q[STAGES-2:0], cs_n};
            ad_q    <= {ad_q[STAGES-2:0], addr};
            wr_last <= wr_q[TOP];
        end
    end

    assign wr_fire = wr_q[TOP] & ~wr_last & ~cs_q[TOP];
    assign addr_s  = ad_q[TOP];

    // R4: an accepted write needs a low strobe before it, so two never come back to back
    p_fire_spaced_r4: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> !wr_fire);
endmodule

// File: rtl/gainctl_regs.sv
module gainctl_regs
    import gainctl_pkg::*;
#(
    parameter bit NINE_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_fire,
    input  logic             addr_s,
    input  logic [BUS_W-1:0] bus_data,
    output ctl_state_t       st,
    output logic             loaded
);
    generate
        if (NINE_BIT) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst)          st <= '0;
                else if (wr_fire) st <= {bus_data, 1'b0};
            end
        end else begin : g_narrow
            always_ff @(posedge clk) begin
                if (rst) begin
                    st <= '0;
                end else if (wr_fire) begin
                    if (!addr_s) begin
                        st.gain.atten           <= bus_data[BUS_W-1];
                        st.gain.coarse          <= bus_data[BUS_W-2 -: CODE_W];
                        st.gain.fine[CODE_W-1:1] <= bus_data[CODE_W-1:1];
                    end else begin
                        st.pdn          <= bus_data[2];
                        st.gain.fine[0] <= bus_data[1];
                    end
                end
            end

            // R2: an address-1 write leaves direction and coarse code alone
            p_addr1_keeps_r2: assert property (@(posedge clk) disable iff (rst)
                (wr_fire && addr_s) |=> ($stable(st.gain.coarse) && $stable(st.gain.atten)));
            // R1: an address-0 write leaves power-down alone
            p_addr0_keeps_r1: assert property (@(posedge clk) disable iff (rst)
                (wr_fire && !addr_s) |=> $stable(st.pdn));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) loaded <= 1'b0;
        else     loaded <= wr_fire;
    end

    // R4: without an accepted write the stored setting holds
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_fire |=> $stable(st));
endmodule

// File: rtl/gainctl_tapdec.sv
module gainctl_tapdec
    import gainctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ctl_state_t      st,
    input  logic            loaded,
    output logic [TAPS-1:0] coarse_tap,
    output logic [TAPS-1:0] fine_tap,
    output logic            atten_sel,
    output logic            analog_en,
    output logic            out_hiz,
    output logic            upd_pulse
);
    localparam int BANKS = 2;

    logic [CODE_W-1:0] codes  [BANKS];
    logic [TAPS-1:0]   taps_q [BANKS];

    assign codes[0] = st.gain.coarse;
    assign codes[1] = st.gain.fine;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) taps_q[b] <= TAPS'(1);
            else     taps_q[b] <= tap_onehot(codes[b]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            atten_sel <= 1'b0;
            analog_en <= 1'b1;
            out_hiz   <= 1'b0;
            upd_pulse <= 1'b0;
        end else begin
            atten_sel <= st.gain.atten;
            analog_en <= ~st.pdn;
            out_hiz   <= st.pdn;
            upd_pulse <= loaded;
        end
    end

    assign coarse_tap = taps_q[0];
    assign fine_tap   = taps_q[1];

    // R6: each tap vector carries exactly one set bit
    p_coarse_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(coarse_tap) == 1);
    p_fine_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $countones(fine_tap) == 1);
    // R9: outputs move only in the cycle the update pulse is shown
    p_quiet_between_r9: assert property (@(posedge clk) disable iff (rst)
        !upd_pulse |-> ($stable(coarse_tap) && $stable(fine_tap) &&
                        $stable(atten_sel) && $stable(out_hiz)));
    // R9: the update pulse lasts one cycle
    p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> !upd_pulse);
endmodule

// File: rtl/gainctl_top.sv
module gainctl_top
    import gainctl_pkg::*;
#(
    parameter bit BUS_NINE    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_strobe,
    input  logic             cs_n,
    input  logic             addr,
    input  logic [BUS_W-1:0] bus_data,
    output logic [TAPS-1:0]  coarse_tap,
    output logic [TAPS-1:0]  fine_tap,
    output logic             atten_sel,
    output logic             analog_en,
    output logic             out_hiz,
    output logic             upd_pulse
);
    logic       wr_fire;
    logic       addr_s;
    logic       loaded;
    ctl_state_t st;

    gainctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .cs_n(cs_n), .addr(addr),
        .wr_fire(wr_fire), .addr_s(addr_s)
    );

    gainctl_regs #(.NINE_BIT(BUS_NINE)) u_regs (
        .clk(clk), .rst(rst), .wr_fire(wr_fire), .addr_s(addr_s),
        .bus_data(bus_data), .st(st), .loaded(loaded)
    );

    gainctl_tapdec u_dec (
        .clk(clk), .rst(rst), .st(st), .loaded(loaded),
        .coarse_tap(coarse_tap), .fine_tap(fine_tap), .atten_sel(atten_sel),
        .analog_en(analog_en), .out_hiz(out_hiz), .upd_pulse(upd_pulse)
    );

    // R7: enable and tristate control always disagree
    p_pd_pair_r7: assert property (@(posedge clk) disable iff (rst)
        analog_en != out_hiz);
endmodule

// File: tb/gainctl_top_test.sv
module gainctl_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_strobe = 1'b0;
    logic       cs_n = 1'b1;
    logic       addr = 1'b0;
    logic [8:0] bus_data = '0;

    logic [15:0] o_coarse [2];
    logic [15:0] o_fine   [2];
    logic        o_atten  [2];
    logic        o_en     [2];
    logic        o_hiz    [2];
    logic        o_upd    [2];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit seen_edge = 1'b0;
    int upd_seen [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    gainctl_top #(.BUS_NINE(1'b0)) uut (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .cs_n(cs_n), .addr(addr),
        .bus_data(bus_data), .coarse_tap(o_coarse[0]), .fine_tap(o_fine[0]),
        .atten_sel(o_atten[0]), .analog_en(o_en[0]), .out_hiz(o_hiz[0]),
        .upd_pulse(o_upd[0])
    );

    gainctl_top #(.BUS_NINE(1'b1)) uut_nine (
        .clk(clk), .rst(rst), .wr_strobe(wr_strobe), .cs_n(cs_n), .addr(addr),
        .bus_data(bus_data), .coarse_tap(o_coarse[1]), .fine_tap(o_fine[1]),
        .atten_sel(o_atten[1]), .analog_en(o_en[1]), .out_hiz(o_hiz[1]),
        .upd_pulse(o_upd[1])
    );

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_atten [2], m_coarse [2], m_fine [2], m_pdn [2];
    int e_coarse [2], e_fine [2], e_atten [2], e_en [2], e_hiz [2], e_upd [2];
    int acc_prev;
    int h_wr [1:3], h_cs [1:3], h_ad [1:3];

    always @(posedge clk) begin
        seen_edge = 1'b1;
        if (rst) begin
            for (int md = 0; md < 2; md++) begin
                m_atten[md] = 0; m_coarse[md] = 0; m_fine[md] = 0; m_pdn[md] = 0;
                e_coarse[md] = 1; e_fine[md] = 1; e_atten[md] = 0;
                e_en[md] = 1; e_hiz[md] = 0; e_upd[md] = 0;
            end
            acc_prev = 0;
            for (int i = 1; i <= 3; i++) begin h_wr[i] = 0; h_cs[i] = 1; h_ad[i] = 0; end
        end else begin
            int acc;
            for (int md = 0; md < 2; md++) begin
                e_coarse[md] = 1 << m_coarse[md];
                e_fine[md]   = 1 << m_fine[md];
                e_atten[md]  = m_atten[md];
                e_en[md]     = m_pdn[md] ? 0 : 1;
                e_hiz[md]    = m_pdn[md];
                e_upd[md]    = acc_prev;
            end
            acc = (h_wr[2] == 1 && h_wr[3] == 0 && h_cs[2] == 0) ? 1 : 0;
            acc_prev = acc;
            if (acc == 1) begin
                // narrow bus: split across two addressed registers
                if (h_ad[2] == 0) begin
                    m_atten[0]  = bus_data[8];
                    m_coarse[0] = bus_data[7:4];
                    m_fine[0]   = (int'(bus_data[3:1]) << 1) | (m_fine[0] & 1);
                end else begin
                    m_pdn[0]  = bus_data[2];
                    m_fine[0] = (m_fine[0] & 14) | int'(bus_data[1]);
                end
                // wide bus: whole word at once, no power-down
                m_atten[1]  = bus_data[8];
                m_coarse[1] = bus_data[7:4];
                m_fine[1]   = bus_data[3:0];
            end
            h_wr[3] = h_wr[2]; h_cs[3] = h_cs[2]; h_ad[3] = h_ad[2];
            h_wr[2] = h_wr[1]; h_cs[2] = h_cs[1]; h_ad[2] = h_ad[1];
            h_wr[1] = wr_strobe; h_cs[1] = cs_n; h_ad[1] = addr;
        end
    end

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            for (int md = 0; md < 2; md++) begin
                chk($sformatf("R1 R6 coarse tap mode%0d", md), o_coarse[md], e_coarse[md]);
                chk($sformatf("R1 R2 R3 R6 fine tap mode%0d", md), o_fine[md], e_fine[md]);
                chk($sformatf("R1 direction mode%0d", md), o_atten[md], e_atten[md]);
                chk($sformatf("R7 analog enable mode%0d", md), o_en[md], e_en[md]);
                chk($sformatf("R7 tristate mode%0d", md), o_hiz[md], e_hiz[md]);
                chk($sformatf("R5 R9 update pulse mode%0d", md), o_upd[md], e_upd[md]);
                if (o_upd[md]) upd_seen[md]++;
            end
        end
    end

    // one bus write; returns the negedge index at which the narrow instance pulsed
    task automatic bus_write(input bit cs, input bit a, input logic [8:0] d,
                             input int hold, output int first_upd);
        @(negedge clk);
        cs_n = cs; addr = a; bus_data = d; wr_strobe = 1'b1;
        first_upd = 0;
        for (int i = 1; i <= hold + 4; i++) begin
            @(negedge clk);
            if (i == hold) wr_strobe = 1'b0;
            if (o_upd[0] && first_upd == 0) first_upd = i;
        end
        cs_n = 1'b1;
    endtask

    initial begin
        int fu;
        int base;
        int seed;
        upd_seen[0] = 0; upd_seen[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset values
        chk("R8 reset coarse", o_coarse[0], 16'h0001);
        chk("R8 reset fine", o_fine[0], 16'h0001);
        chk("R8 reset direction", o_atten[0], 0);
        chk("R8 reset power-down", o_hiz[0], 0);
        chk("R8 reset pulse", o_upd[0], 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 R5: address 0, bit 0 set to show it is ignored in narrow mode
        bus_write(1'b0, 1'b0, 9'h1AF, 3, fu);
        chk("R5 latency of first update", fu, 4);
        chk("R1 coarse code 10", o_coarse[0], 16'h0400);
        chk("R1 fine bits 3..1, bit0 untouched", o_fine[0], 16'h4000);
        chk("R3 wide bus fine 15", o_fine[1], 16'h8000);
        // R2: address 1 sets power-down and fine bit 0, junk elsewhere
        bus_write(1'b0, 1'b1, 9'h1F6, 3, fu);
        chk("R2 fine bit0 set", o_fine[0], 16'h8000);
        chk("R2 coarse kept", o_coarse[0], 16'h0400);
        chk("R7 powered down", o_hiz[0], 1);
        chk("R3 wide bus never powers down", o_hiz[1], 0);
        // R7: writes still accepted while powered down
        bus_write(1'b0, 1'b0, 9'h030, 3, fu);
        chk("R7 write accepted in power-down", o_coarse[0], 16'h0008);
        chk("R7 still powered down", o_hiz[0], 1);
        // R4: chip select high, write ignored
        bus_write(1'b1, 1'b0, 9'h1F0, 3, fu);
        chk("R4 cs high no pulse", fu, 0);
        chk("R4 cs high coarse kept", o_coarse[0], 16'h0008);
        // R2: clear power-down
        bus_write(1'b0, 1'b1, 9'h000, 3, fu);
        chk("R2 power-down cleared", o_en[0], 1);
        // R4 R9: long strobe gives one write; same value still pulses
        base = upd_seen[0];
        bus_write(1'b0, 1'b1, 9'h000, 20, fu);
        chk("R4 R9 one pulse per long strobe", upd_seen[0] - base, 1);
        // R6: extreme codes
        bus_write(1'b0, 1'b0, 9'h0F0, 3, fu);
        chk("R6 coarse code 15", o_coarse[0], 16'h8000);
        bus_write(1'b0, 1'b0, 9'h000, 3, fu);
        chk("R6 coarse code 0", o_coarse[0], 16'h0001);

        // pseudo-random traffic, R3 addr has no effect on the wide bus
        seed = 32'h1357;
        for (int n = 0; n < 60; n++) begin
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            bus_write(seed[20], seed[9], seed[8:0], 3 + (seed[12:11]), fu);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule